// File: doc/BRIEF.md
# Laser Shot Acquisition Window Sequencer

This block times a single laser shot's acquisition window. A fire command received while the block is idle raises a fire request toward the laser. The laser answers with an acknowledge, and that acknowledge starts a range-gate delay counter. When the delay runs out, a second counter holds the capture-enable output high for a programmed number of cycles. When that count ends, a one-cycle done pulse reports that the shot is complete. All lengths are counted in system clock cycles. Shots arrive at a low rate, nominally forty per second, and each shot yields one data set for the sample path downstream.

The delay, window length, return gain and acknowledge limit are copied into shadow registers at the fire command. Register writes made during a shot therefore leave that shot unchanged. An amplifier gain select carries the transmit setting from the fire command through the end of the delay. It switches to the return setting when capture starts. Two sticky flags record error conditions: a fire command that arrives outside idle, and an acknowledge that never came.

Top module: `shot_window_seq`

## Requirements
- R1: After reset, fire_req, capture_en, shot_done, overrun_flag and ack_to_flag are 0 and gain_sel is 0.
- R2: A fire_cmd sampled while idle makes fire_req high from the next cycle. fire_req stays high until an acknowledge is accepted or the acknowledge limit is reached.
- R3: An acknowledge sampled while fire_req is high starts the delay phase. The delay phase lasts max(cfg_delay,1) cycles. An acknowledge on the last permitted waiting cycle is still accepted.
- R4: capture_en is high for exactly max(cfg_period,1) consecutive cycles, starting the cycle after the delay phase ends. It is never high together with fire_req.
- R5: shot_done is a single-cycle pulse in the cycle right after capture_en falls. The block is idle in the following cycle.
- R6: gain_sel equals the transmit gain from the cycle after the fire command through the delay phase. It equals the return gain from the first capture cycle on, and holds that value until the next fire.
- R7: cfg_delay, cfg_period, cfg_ack_limit, cfg_gain_tx and cfg_gain_rx are sampled at the fire command. Changing them later has no effect on the shot in progress.
- R8: A fire_cmd sampled while not idle is ignored, so the current shot's timing is unchanged. It sets overrun_flag from the next cycle.
- R9: If no acknowledge arrives within max(cfg_ack_limit,1) waiting cycles, fire_req drops and the block returns to idle with no capture and no done pulse. ack_to_flag is set from the next cycle.
- R10: Both flags are sticky until clr_flags is sampled high. A set event in the same cycle as clr_flags wins.
- R11: fire_ack is ignored while the block is not waiting for an acknowledge, whether it is idle or in the delay phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_cmd | input | 1 | Request to start a shot |
| fire_ack | input | 1 | Laser fired acknowledge |
| cfg_delay | input | DLY_W | Range-gate delay length in cycles |
| cfg_period | input | PER_W | Capture window length in cycles |
| cfg_ack_limit | input | ACK_W | Maximum acknowledge wait in cycles |
| cfg_gain_tx | input | GAIN_W | Gain code for the outgoing pulse |
| cfg_gain_rx | input | GAIN_W | Gain code for the return |
| clr_flags | input | 1 | Clears both sticky flags |
| fire_req | output | 1 | Fire request to the laser |
| capture_en | output | 1 | Acquisition window open |
| gain_sel | output | GAIN_W | Amplifier gain select |
| shot_done | output | 1 | One-cycle end-of-shot pulse |
| overrun_flag | output | 1 | Sticky: fire command arrived while busy |
| ack_to_flag | output | 1 | Sticky: acknowledge wait expired |

## Verification
The hardest conditions to reach from the ports are edge cases of timing. One is an acknowledge that lands on the very cycle the wait limit expires. Another is a fire command that arrives in the middle of a capture window. A third is an acknowledge held high into the delay phase, where it must not restart the counter. The stimulus table places the acknowledge at a chosen cycle index relative to the first fire_req cycle, holds it for a chosen number of cycles, and can inject a fire command on the first capture cycle. After every fire the bench scrambles the configuration inputs, so each observed phase length also confirms the sampling at fire time.

// File: rtl/shot_seq_pkg.sv
package shot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_ACK = 3'd1,
        ST_DELAY    = 3'd2,
        ST_CAPTURE  = 3'd3,
        ST_DONE     = 3'd4
    } seq_state_e;

endpackage

// File: rtl/phase_timer.sv
// Loadable down-counter. Once loaded with N, it reports expiry on the
// max(N,1)-th cycle in which run is high.
module phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         run,
    output logic         expire
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q <= ONE);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = len;
        end else if (run && !expire) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sticky_flag.sv
// Sticky status bit; a set in the same cycle as a clear takes priority.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = set | (flag_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/shot_window_seq.sv
module shot_window_seq
    import shot_seq_pkg::*;
#(
    parameter int DLY_W  = 16,
    parameter int PER_W  = 16,
    parameter int ACK_W  = 12,
    parameter int GAIN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_cmd,
    input  logic              fire_ack,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic [ACK_W-1:0]  cfg_ack_limit,
    input  logic [GAIN_W-1:0] cfg_gain_tx,
    input  logic [GAIN_W-1:0] cfg_gain_rx,
    input  logic              clr_flags,
    output logic              fire_req,
    output logic              capture_en,
    output logic [GAIN_W-1:0] gain_sel,
    output logic              shot_done,
    output logic              overrun_flag,
    output logic              ack_to_flag
);
    typedef struct packed {
        seq_state_e        state;
        logic [DLY_W-1:0]  sh_delay;
        logic [PER_W-1:0]  sh_period;
        logic [GAIN_W-1:0] sh_gain_rx;
        logic [GAIN_W-1:0] gain;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic in_idle, in_wait, in_delay, in_capture;
    logic ack_load, dly_load, per_load;
    logic ack_exp, dly_exp, per_exp;
    logic fire_accept, ack_accept;

    assign in_idle    = (ctl_q.state == ST_IDLE);
    assign in_wait    = (ctl_q.state == ST_WAIT_ACK);
    assign in_delay   = (ctl_q.state == ST_DELAY);
    assign in_capture = (ctl_q.state == ST_CAPTURE);

    assign fire_accept = in_idle && fire_cmd;
    assign ack_accept  = in_wait && fire_ack;
    assign ack_load    = fire_accept;
    assign dly_load    = ack_accept;
    assign per_load    = in_delay && dly_exp;

    // Acknowledge wait; its length is taken from the live input at fire time.
    phase_timer #(.W(ACK_W)) u_ack_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ack_load),
        .len    (cfg_ack_limit),
        .run    (in_wait),
        .expire (ack_exp)
    );

    // Range-gate delay, started by the laser acknowledge.
    phase_timer #(.W(DLY_W)) u_dly_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (dly_load),
        .len    (ctl_q.sh_delay),
        .run    (in_delay),
        .expire (dly_exp)
    );

    // Capture window, started by delay expiry.
    phase_timer #(.W(PER_W)) u_per_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (per_load),
        .len    (ctl_q.sh_period),
        .run    (in_capture),
        .expire (per_exp)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (fire_cmd) begin
                    ctl_d.state      = ST_WAIT_ACK;
                    ctl_d.sh_delay   = cfg_delay;
                    ctl_d.sh_period  = cfg_period;
                    ctl_d.sh_gain_rx = cfg_gain_rx;
                    ctl_d.gain       = cfg_gain_tx;
                end
            end
            ST_WAIT_ACK: begin
                if (fire_ack)     ctl_d.state = ST_DELAY;
                else if (ack_exp) ctl_d.state = ST_IDLE;
            end
            ST_DELAY: begin
                if (dly_exp) begin
                    ctl_d.state = ST_CAPTURE;
                    ctl_d.gain  = ctl_q.sh_gain_rx;
                end
            end
            ST_CAPTURE: begin
                if (per_exp) ctl_d.state = ST_DONE;
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state      <= ST_IDLE;
            ctl_q.sh_delay   <= '0;
            ctl_q.sh_period  <= '0;
            ctl_q.sh_gain_rx <= '0;
            ctl_q.gain       <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sticky_flag u_overrun (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fire_cmd && !in_idle),
        .clr   (clr_flags),
        .flag  (overrun_flag)
    );

    sticky_flag u_ack_to (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (in_wait && !fire_ack && ack_exp),
        .clr   (clr_flags),
        .flag  (ack_to_flag)
    );

    assign fire_req   = in_wait;
    assign capture_en = in_capture;
    assign shot_done  = (ctl_q.state == ST_DONE);
    assign gain_sel   = ctl_q.gain;
endmodule

// File: rtl/shot_window_seq_chk.sv
module shot_window_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fire_cmd,
    input logic fire_ack,
    input logic clr_flags,
    input logic fire_req,
    input logic capture_en,
    input logic shot_done,
    input logic overrun_flag,
    input logic ack_to_flag
);
    // R2
    req_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire_req) |-> $past(fire_cmd));

    // R4
    req_cap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_req && capture_en));

    // R5
    done_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(capture_en) |-> shot_done);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shot_done |=> (!shot_done && !capture_en && !fire_req));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_cmd && (fire_req || capture_en || shot_done)) |=> overrun_flag);

    // R9
    ack_to_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_to_flag) |-> ($past(fire_req) && !$past(fire_ack) && !fire_req));

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_flag && !clr_flags) |=> overrun_flag);

    // R10
    ack_to_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_to_flag && !clr_flags) |=> ack_to_flag);
endmodule

bind shot_window_seq shot_window_seq_chk u_chk (.*);

// File: tb/tb_shot_window_seq.sv
`timescale 1ns/1ps
module tb_shot_window_seq;
    localparam logic [2:0] TX = 3'd5;
    localparam logic [2:0] RX = 3'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fire_cmd = 1'b0;
    logic        fire_ack = 1'b0;
    logic [15:0] cfg_delay = '0;
    logic [15:0] cfg_period = '0;
    logic [11:0] cfg_ack_limit = '0;
    logic [2:0]  cfg_gain_tx = '0;
    logic [2:0]  cfg_gain_rx = '0;
    logic        clr_flags = 1'b0;
    logic        fire_req, capture_en, shot_done, overrun_flag, ack_to_flag;
    logic [2:0]  gain_sel;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    shot_window_seq dut (
        .clk(clk), .rst_n(rst_n), .fire_cmd(fire_cmd), .fire_ack(fire_ack),
        .cfg_delay(cfg_delay), .cfg_period(cfg_period), .cfg_ack_limit(cfg_ack_limit),
        .cfg_gain_tx(cfg_gain_tx), .cfg_gain_rx(cfg_gain_rx), .clr_flags(clr_flags),
        .fire_req(fire_req), .capture_en(capture_en), .gain_sel(gain_sel),
        .shot_done(shot_done), .overrun_flag(overrun_flag), .ack_to_flag(ack_to_flag)
    );

    typedef struct packed {
        int d;
        int p;
        int a;
        int wt;
        int hold;
        bit poke;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3,  4,  10, 2,  1, 1'b0},
        '{1,  1,  5,  0,  1, 1'b0},
        '{0,  0,  5,  1,  1, 1'b0},
        '{6,  5,  4,  3,  1, 1'b0},
        '{4,  3,  4,  4,  2, 1'b0},
        '{5,  6,  8,  1,  4, 1'b1},
        '{20, 17, 30, 12, 1, 1'b1},
        '{2,  9,  0,  0,  1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    task automatic run_shot(input vec_t v);
        int  dd = (v.d < 1) ? 1 : v.d;
        int  pp = (v.p < 1) ? 1 : v.p;
        int  aa = (v.a < 1) ? 1 : v.a;
        bit  acked = (v.wt < aa);
        int  n_req = 0, n_dly = 0, n_cap = 0, n_done = 0, bad_tx = 0, bad_rx = 0;
        int  total = aa + dd + pp + v.hold + v.wt + 8;
        clear_flags();
        chk("R10 overrun cleared", int'(overrun_flag), 0);
        cfg_delay     = 16'(v.d);
        cfg_period    = 16'(v.p);
        cfg_ack_limit = 12'(v.a);
        cfg_gain_tx   = TX;
        cfg_gain_rx   = RX;
        fire_cmd      = 1'b1;
        @(negedge clk);
        fire_cmd = 1'b0;
        // R7: scramble configuration after the fire command
        cfg_delay     = 16'(v.d + 5);
        cfg_period    = 16'(v.p + 7);
        cfg_ack_limit = 12'(v.a + 3);
        cfg_gain_tx   = 3'd0;
        cfg_gain_rx   = 3'd7;
        for (int c = 0; c < total; c++) begin
            if (fire_req) begin
                n_req++;
                if (gain_sel != TX) bad_tx++;
            end
            if (acked && n_req > 0 && n_cap == 0 && !fire_req && !capture_en && !shot_done) begin
                n_dly++;
                if (gain_sel != TX) bad_tx++;
            end
            if (capture_en) begin
                n_cap++;
                if (gain_sel != RX) bad_rx++;
            end
            if (shot_done) n_done++;
            fire_ack = (c >= v.wt) && (c < v.wt + v.hold);
            fire_cmd = v.poke && capture_en && (n_cap == 1);
            @(negedge clk);
        end
        fire_ack = 1'b0;
        fire_cmd = 1'b0;
        chk("R2 fire_req cycles", n_req, acked ? v.wt + 1 : aa);
        if (acked) begin
            chk("R3 R7 R11 delay cycles", n_dly, dd);
            chk("R4 R7 R8 capture cycles", n_cap, pp);
            chk("R5 done pulses", n_done, 1);
            chk("R6 tx gain", bad_tx, 0);
            chk("R6 R7 rx gain", bad_rx, 0);
            chk("R6 gain held", int'(gain_sel), int'(RX));
            chk("R8 overrun flag", int'(overrun_flag), int'(v.poke));
            chk("R3 no ack timeout", int'(ack_to_flag), 0);
        end else begin
            chk("R9 no capture", n_cap, 0);
            chk("R9 no done", n_done, 0);
            chk("R9 ack timeout flag", int'(ack_to_flag), 1);
            chk("R11 late ack ignored", int'(fire_req), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fire_req", int'(fire_req), 0);
        chk("R1 capture_en", int'(capture_en), 0);
        chk("R1 shot_done", int'(shot_done), 0);
        chk("R1 overrun_flag", int'(overrun_flag), 0);
        chk("R1 ack_to_flag", int'(ack_to_flag), 0);
        chk("R1 gain_sel", int'(gain_sel), 0);

        for (int i = 0; i < NV; i++) run_shot(VECS[i]);

        // R11: acknowledge while idle starts nothing
        fire_ack = 1'b1;
        @(negedge clk);
        fire_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 idle ack fire_req", int'(fire_req), 0);
        chk("R11 idle ack capture", int'(capture_en), 0);

        // R10: set wins over a simultaneous clear
        clear_flags();
        cfg_ack_limit = 12'd3;
        fire_cmd = 1'b1;
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        fire_cmd = 1'b0;
        clr_flags = 1'b0;
        chk("R10 set beats clear", int'(overrun_flag), 1);
        repeat (4) @(negedge clk);
        chk("R9 flag after wait", int'(ack_to_flag), 1);
        chk("R10 overrun kept", int'(overrun_flag), 1);
        clear_flags();
        chk("R10 overrun cleared", int'(overrun_flag), 0);
        chk("R10 ack_to cleared", int'(ack_to_flag), 0);

        // R1: reset in mid-shot returns outputs to idle values
        fire_cmd = 1'b1;
        @(negedge clk);
        fire_cmd = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-shot fire_req", int'(fire_req), 0);
        chk("R1 reset mid-shot gain", int'(gain_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule